// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block is a memory-mapped timer that several harts share. It keeps one 64-bit time counter. The counter advances by one on each pulse of an external timebase strobe. The block also holds one 64-bit compare register per hart and drives one level-sensitive timer interrupt per hart. Each interrupt stays high for as long as the time counter is at or above that hart's compare value.

Software reaches the registers over a simple register bus. The bus has an address, 64-bit write data, read and write strobes, and a size bit that picks a 4-byte or an 8-byte access. Both 32-bit halves and the full 64-bit value can be read or written, for the compare registers and for the time counter. The interrupt lines are compared against the registers every cycle. A write that moves a compare value or the time counter therefore shows up on the interrupt lines in the cycle after the write. An access the block does not decode raises a one-cycle error flag.

Top module: `hart_timer_cmp`

## Requirements
- R1: At reset every compare register and the time counter are 0. All interrupt lines are therefore high once reset is released.
- R2: Each cycle in which `tick` is high and no write to the time counter takes place, the time counter grows by exactly one.
- R3: The compare slot of hart h starts at CMP_BASE + 8·h. A 4-byte write at slot offset 0 replaces bits 31:0 with `bus_wdata[31:0]` and keeps bits 63:32.
- R4: A 4-byte write at slot offset 4 replaces bits 63:32 with `bus_wdata[31:0]` and keeps bits 31:0.
- R5: An 8-byte write at slot offset 0 replaces all 64 bits of that hart's compare register and touches no other hart.
- R6: Read data appears on `bus_rdata` one cycle after the read strobe. A 4-byte read at offset 0 returns bits 31:0, an 8-byte read at offset 0 returns all 64 bits, and a 4-byte read at offset 4 returns bits 63:32. In the 4-byte cases the upper 32 bits of `bus_rdata` are zero.
- R7: `timer_irq[h]` is high exactly when time ≥ compare[h]. Writing a future compare value drops the line in the cycle after the write. The line rises on the first tick that makes time reach the compare value.
- R8: A 4-byte write at TIME_BASE replaces the low half of the time counter and a 4-byte write at TIME_BASE+4 replaces the high half, each keeping the other half. An 8-byte write at TIME_BASE replaces all 64 bits. Every interrupt is re-evaluated against the new time.
- R9: An 8-byte write at TIME_BASE+4 leaves the time counter unchanged and raises `bus_err` for one cycle.
- R10: An access to an unmapped address raises `bus_err` for one cycle, reads as zero and changes no register. Unmapped addresses are: at or beyond CMP_BASE + 8·NUM_HARTS, not 4-byte aligned, or an 8-byte access at a compare slot's offset 4.
- R11: When a time-counter write and a `tick` fall in the same cycle, the written value is stored and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one increment per high cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| bus_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 64 | Read data, valid one cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse for an undecoded or illegal access |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
Read data and the error flag are due one cycle after the strobe. Register writes and ticks reach `timer_irq` in that same next cycle, because the compare logic that follows the registers is purely combinational.

The driver puts a strobe on the bus at a falling edge and pushes the expected result into a queue. The monitor pops that item at the next falling edge, after the registering rising edge has passed. Interrupt levels and register contents are checked at that same falling edge after each write or tick. The timing of every check therefore depends on exactly one register stage.

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'hBFF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [63:0]          bus_wdata,
  input  logic                 bus_size8,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [63:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam int SPAN  = 8 * NUM_HARTS;
  localparam logic [ADDR_W-1:0] TIME_HI = TIME_BASE + ADDR_W'(4);

  logic [63:0] time_q;
  logic [63:0] cmp_q [NUM_HARTS];

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic in_cmp, aligned, hi, cmp_ok, at_tlo, at_thi, time_ok, legal, time_wr;

  assign rel     = bus_addr - CMP_BASE;
  assign idx     = rel[IDX_W+2:3];
  assign hi      = bus_addr[2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign in_cmp  = (bus_addr >= CMP_BASE) && (32'(rel) < 32'(SPAN));
  assign cmp_ok  = in_cmp && aligned && !(hi && bus_size8);
  assign at_tlo  = (bus_addr == TIME_BASE);
  assign at_thi  = (bus_addr == TIME_HI);
  assign time_ok = at_tlo || (at_thi && !bus_size8);
  assign legal   = cmp_ok || time_ok;
  assign time_wr = bus_wr && time_ok;

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                        input logic s8, input logic h);
    if (s8)     return wd;
    else if (h) return {wd[31:0], old[31:0]};
    else        return {old[63:32], wd[31:0]};
  endfunction

  function automatic logic [63:0] pick(input logic [63:0] v, input logic s8, input logic h);
    if (h)       return {32'h0, v[63:32]};
    else if (s8) return v;
    else         return {32'h0, v[31:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_wr) time_q <= merge(time_q, bus_wdata, bus_size8, at_thi);
    else if (tick)    time_q <= time_q + 64'd1;
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_q[h] <= '0;
      else if (bus_wr && cmp_ok && (32'(idx) == h))
        cmp_q[h] <= merge(cmp_q[h], bus_wdata, bus_size8, hi);
    end
    assign timer_irq[h] = (time_q >= cmp_q[h]);
  end

  logic [63:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (cmp_ok)       rd_val = pick(cmp_q[idx], bus_size8, hi);
    else if (time_ok) rd_val = pick(time_q, bus_size8, at_thi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      bus_err <= (bus_rd || bus_wr) && !legal;
    end
  end

  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !time_wr |=> time_q == $past(time_q) + 64'd1);

  a_r9_bad_time_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && at_thi && bus_size8 && !tick |=> $stable(time_q) && bus_err);

  a_r10_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err && $past(bus_rd) |-> bus_rdata == 64'h0);

  a_r10_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd || bus_wr) |-> !bus_err);

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) && !$past(tick) |-> $stable(timer_irq));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && at_tlo && bus_size8 |=> time_q == $past(bus_wdata));
endmodule

// File: tb/test_hart_timer_cmp.sv
module test_hart_timer_cmp;
  localparam int N = 4;
  localparam logic [15:0] CB = 16'h4000;
  localparam logic [15:0] TB = 16'hBFF8;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic bus_size8 = 0, bus_wr = 0, bus_rd = 0;
  logic [63:0] bus_rdata;
  logic bus_err;
  logic [N-1:0] timer_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hart_timer_cmp #(.NUM_HARTS(N), .ADDR_W(16), .CMP_BASE(CB), .TIME_BASE(TB)) i_hart_timer_cmp (
    .clk, .rst_n, .tick, .bus_addr, .bus_wdata, .bus_size8, .bus_wr, .bus_rd,
    .bus_rdata, .bus_err, .timer_irq);

  typedef struct { bit is_rd; logic [63:0] data; bit err; string tag; } item_t;
  item_t q[$];
  bit pend = 0;

  always @(posedge clk) pend <= bus_rd || bus_wr;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (pend) begin
    item_t it;
    if (q.size() == 0) check(0, "scoreboard underflow", 0, 0);
    else begin
      it = q.pop_front();
      check(bus_err === it.err, {it.tag, " err"}, 64'(bus_err), 64'(it.err));
      if (it.is_rd) check(bus_rdata === it.data, {it.tag, " rdata"}, bus_rdata, it.data);
    end
  end

  task automatic wr(input logic [15:0] a, input bit s8, input logic [63:0] d,
                    input bit ee, input string tag, input bit tk = 0);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_size8 = s8; bus_wdata = d; bus_wr = 1; tick = tk;
    it.is_rd = 0; it.data = 0; it.err = ee; it.tag = tag; q.push_back(it);
    @(negedge clk);
    bus_wr = 0; tick = 0;
  endtask

  task automatic rd(input logic [15:0] a, input bit s8, input logic [63:0] exp,
                    input bit ee, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_size8 = s8; bus_rd = 1;
    it.is_rd = 1; it.data = exp; it.err = ee; it.tag = tag; q.push_back(it);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic irq_is(input logic [N-1:0] exp, input string tag);
    check(timer_irq === exp, tag, 64'(timer_irq), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    irq_is(4'b1111, "R1 irq after reset");
    rd(TB, 1, 64'h0, 0, "R1 time reset");
    rd(CB + 16'd16, 1, 64'h0, 0, "R1 cmp2 reset");

    wr(CB, 1, 64'd10, 0, "R5 cmp0 full write");
    irq_is(4'b1110, "R7 R5 future cmp drops irq0 only");
    rd(CB, 1, 64'd10, 0, "R6 R5 cmp0 full read");

    wr(CB + 16'd8, 0, 64'hAAAA_BBBB_FFFF_FFFF, 0, "R3 cmp1 low write");
    rd(CB + 16'd8, 1, 64'h0000_0000_FFFF_FFFF, 0, "R3 cmp1 high kept");
    wr(CB + 16'd12, 0, 64'hDEAD_0000_0000_0001, 0, "R4 cmp1 high write");
    rd(CB + 16'd8, 1, 64'h0000_0001_FFFF_FFFF, 0, "R4 cmp1 low kept");
    rd(CB + 16'd12, 0, 64'h1, 0, "R6 cmp1 high read");
    rd(CB + 16'd8, 0, 64'hFFFF_FFFF, 0, "R6 cmp1 low read");
    irq_is(4'b1100, "R7 cmp1 future");

    ticks(9);
    irq_is(4'b1100, "R7 irq0 low at time 9");
    ticks(1);
    irq_is(4'b1101, "R7 R2 irq0 rises at time 10");
    rd(TB, 1, 64'd10, 0, "R2 time after 10 ticks");

    wr(TB, 0, 64'h1234_5678, 0, "R8 time low write");
    rd(TB, 1, 64'h1234_5678, 0, "R8 time low result");
    wr(TB + 16'd4, 0, 64'h1, 0, "R8 time high write");
    rd(TB, 1, 64'h1_1234_5678, 0, "R8 time high result");
    rd(TB + 16'd4, 0, 64'h1, 0, "R6 time high read");
    irq_is(4'b1101, "R8 irq1 still low");
    wr(TB, 1, 64'h2_0000_0000, 0, "R8 time full write");
    irq_is(4'b1111, "R8 irq1 re-evaluated");

    wr(TB + 16'd4, 1, 64'h0, 1, "R9 8-byte time high write");
    rd(TB, 1, 64'h2_0000_0000, 0, "R9 time unchanged");

    wr(CB + 16'd32, 1, 64'h5, 1, "R10 beyond last slot write");
    rd(CB + 16'd32, 1, 64'h0, 1, "R10 beyond last slot read");
    wr(CB + 16'd2, 0, 64'h7, 1, "R10 misaligned write");
    wr(CB + 16'd4, 1, 64'h7, 1, "R10 8-byte at slot offset 4");
    rd(CB, 1, 64'd10, 0, "R10 cmp0 untouched");
    rd(CB + 16'd24, 1, 64'h0, 0, "R10 cmp3 untouched");
    irq_is(4'b1111, "R10 irqs unchanged");

    wr(CB + 16'd16, 1, 64'h3_0000_0000, 0, "R5 cmp2 full write");
    irq_is(4'b1011, "R7 cmp2 future drops irq2");
    wr(TB, 1, 64'h2_FFFF_FFFF, 0, "R11 write with tick", 1);
    rd(TB, 1, 64'h2_FFFF_FFFF, 0, "R11 tick dropped");
    irq_is(4'b1011, "R7 irq2 low one before");
    ticks(1);
    irq_is(4'b1111, "R7 irq2 rises on tick");

    repeat (3) @(negedge clk);
    if (q.size() != 0) check(0, "scoreboard leftover", 64'(q.size()), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule